// File: doc/BRIEF.md
# Frame Sync Generator

This block produces the bit clock and the periodic frame-sync strobe for a serial audio port. It runs on the system clock. The bit clock comes from one of two places: an internal divider, or an external clock pin. The frame-sync pulse is counted out in bit clocks. Its frame length and its active width are both programmed as a count minus one, and its output polarity can be chosen. The block can also sit idle and pass the external clock and frame-sync pins straight through when a codec is the timing master.

The block has two enables. The clock stage must run before the frame stage can do anything, and removing either enable returns both outputs to their quiet levels. In periodic mode the strobe repeats every frame. In one-shot mode each request strobe buys exactly one frame. All frame-sync changes line up with the falling (driving) edge of the bit clock.

Top module: `frame_sync_gen`

## Requirements
- R1: While reset is held, `bclk_out` is 0 and `fs_out` equals `fs_inv` (inactive level).
- R2: In mode 0, with the clock stage enabled, `bclk_out` has a period of L+1 system cycles, where L = `div`, or L = 1 when `div` is 0. After each falling edge it stays low for floor((L+1)/2) cycles and is high for the remaining cycles.
- R3: In periodic mode, successive frame-sync activations are exactly `period_m1`+1 bit-clock falling edges apart.
- R4: The strobe stays active for `width_m1`+1 bit clocks. When `width_m1` >= `period_m1`, the strobe stays active without a break.
- R5: With `fs_inv` = 0 the internally generated strobe is active high; with `fs_inv` = 1 it is active low. When idle, it rests at the level of `fs_inv`.
- R6: In mode 0 the strobe changes only on the same system-clock edge as a falling edge of `bclk_out`.
- R7: Once both enables are high, the frame counter starts at zero and the first activation occurs on the first bit-clock falling edge that the generator sees.
- R8: With `periodic` = 0 no frame starts without a `xfer_req` pulse. Each request starts exactly one frame. A request that arrives during a frame is held and starts the next frame back to back.
- R9: The frame stage runs only while both `clk_en` and `fs_en` are high. If `fs_en` is high while `clk_en` is low, the strobe stays inactive and `bclk_out` stays low. Dropping `clk_en` returns both outputs to idle within two cycles.
- R10: In mode 1, `bclk_out` follows `ext_bclk_in`. Frames are counted on the synchronized falling edges of `ext_bclk_in`, and R3 and R4 apply.
- R11: In modes 2 and 3, `bclk_out` = `ext_bclk_in` and `fs_out` = `ext_fs_in`, with no polarity applied. The generator stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 internal clock, 1 external clock with internal strobe, 2/3 pass-through |
| clk_en | input | 1 | Clock stage enable |
| fs_en | input | 1 | Frame stage enable |
| periodic | input | 1 | 1 continuous frames, 0 one frame per request |
| fs_inv | input | 1 | Strobe polarity, 1 = active low |
| div | input | DIV_W | Bit-clock divisor minus one |
| period_m1 | input | CNT_W | Bit clocks per frame minus one |
| width_m1 | input | CNT_W | Active strobe bit clocks minus one |
| xfer_req | input | 1 | One-shot frame request strobe |
| ext_bclk_in | input | 1 | External bit clock pin |
| ext_fs_in | input | 1 | External frame-sync pin |
| bclk_out | output | 1 | Bit clock output |
| fs_out | output | 1 | Frame-sync output |

## Verification
The bench measures the frame length and the strobe width in bit-clock edges across random divisors, periods, widths and polarities. An off-by-one in either counter shows up as a frame or pulse one bit clock too long. It looks for the first pulse right after enable: a design that starts the counter mid-frame would delay that pulse. It also covers a width at or beyond the period, where a design that does not clip the width would drop the strobe once per frame. In one-shot mode it checks three cases: a frame that appears with no request, a request that is lost during a frame, and two requests merged into one. It also checks that raising the frame enable without the clock enable leaves both outputs quiet, and that pass-through does not apply the polarity bit.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef enum logic [1:0] {
      FSG_INT_CLK   = 2'd0,
      FSG_EXT_CLK   = 2'd1,
      FSG_SLAVE     = 2'd2,
      FSG_SLAVE_ALT = 2'd3
   } fsg_mode_e;
endpackage

// File: rtl/fsg_bclk_div.sv
module fsg_bclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             bclk,
   output logic             tick
);
   localparam logic [DIV_W-1:0] MIN_LAST = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;
   logic [DIV_W-1:0] half;
   logic [DIV_W:0]   span;

   // a divisor of zero is treated as one so the clock can still toggle
   assign last = (div == '0) ? MIN_LAST : div;
   assign span = {1'b0, last} + {{DIV_W{1'b0}}, 1'b1};
   assign half = span[DIV_W:1];
   assign tick = run && (cnt >= last);
   assign bclk = (cnt >= half);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   AST_BCLK_FALL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && $fell(bclk)) |-> $past(tick)); // R2
endmodule

// File: rtl/fsg_edge_sync.sv
module fsg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sh <= '0;
      else
         sh <= {sh[STAGES-1:0], din};
   end

   assign fall = sh[STAGES] & ~sh[STAGES-1];

   AST_SINGLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R10
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             periodic,
   input  logic             req,
   input  logic [CNT_W-1:0] period_m1,
   input  logic [CNT_W-1:0] width_m1,
   output logic             fs_act
);
   logic [CNT_W-1:0] pcnt;
   logic [CNT_W:0]   pnext;
   logic             in_frame;
   logic             pending;
   logic             frame_done;
   logic             want_start;
   logic             consume;

   assign pnext      = {1'b0, pcnt} + {{CNT_W{1'b0}}, 1'b1};
   assign frame_done = !in_frame || (pcnt >= period_m1);
   assign want_start = periodic || pending;
   assign consume    = tick && frame_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt     <= '0;
         in_frame <= 1'b0;
         pending  <= 1'b0;
         fs_act   <= 1'b0;
      end else if (!run) begin
         pcnt     <= '0;
         in_frame <= 1'b0;
         pending  <= 1'b0;
         fs_act   <= 1'b0;
      end else begin
         pending <= !periodic && ((pending && !consume) || req);
         if (tick) begin
            if (frame_done) begin
               pcnt     <= '0;
               in_frame <= want_start;
               fs_act   <= want_start;
            end else begin
               pcnt   <= pnext[CNT_W-1:0];
               fs_act <= (pnext <= {1'b0, width_m1});
            end
         end
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $past(tick)) |-> (pcnt <= $past(period_m1))); // R3
   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && $past(tick) && $rose(in_frame)) |-> (fs_act && pcnt == '0)); // R7
   AST_ONESHOT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && $past(tick) && !$past(periodic) && $rose(in_frame)) |-> $past(pending)); // R8
   AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> (!fs_act && !in_frame)); // R9
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
   parameter int DIV_W       = 8,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_CLK_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             clk_en,
   input  logic             fs_en,
   input  logic             periodic,
   input  logic             fs_inv,
   input  logic [DIV_W-1:0] div,
   input  logic [CNT_W-1:0] period_m1,
   input  logic [CNT_W-1:0] width_m1,
   input  logic             xfer_req,
   input  logic             ext_bclk_in,
   input  logic             ext_fs_in,
   output logic             bclk_out,
   output logic             fs_out
);
   import fsg_pkg::*;

   fsg_mode_e mode_e;
   logic      is_int;
   logic      is_ext;
   logic      is_pass;
   logic      div_run;
   logic      fs_run;
   logic      bclk_int;
   logic      int_tick;
   logic      ext_fall;
   logic      tick;
   logic      fs_act;

   if (DIV_W < 1 || CNT_W < 1 || SYNC_STAGES < 2) begin : g_bad_param
      initial $error("frame_sync_gen: DIV_W, CNT_W >= 1 and SYNC_STAGES >= 2 required");
   end

   assign mode_e  = fsg_mode_e'(mode);
   assign is_int  = (mode_e == FSG_INT_CLK);
   assign is_ext  = (mode_e == FSG_EXT_CLK);
   assign is_pass = (mode_e == FSG_SLAVE) || (mode_e == FSG_SLAVE_ALT);
   assign div_run = clk_en && is_int;
   assign fs_run  = clk_en && fs_en && !is_pass;

   fsg_bclk_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (div_run),
      .div   (div),
      .bclk  (bclk_int),
      .tick  (int_tick)
   );

   if (EXT_CLK_EN) begin : g_ext
      fsg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (ext_bclk_in),
         .fall  (ext_fall)
      );
   end else begin : g_no_ext
      assign ext_fall = 1'b0;
   end

   assign tick = is_ext ? (clk_en && ext_fall) : int_tick;

   fsg_frame_ctr #(.CNT_W(CNT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (fs_run),
      .tick      (tick),
      .periodic  (periodic),
      .req       (xfer_req),
      .period_m1 (period_m1),
      .width_m1  (width_m1),
      .fs_act    (fs_act)
   );

   assign bclk_out = is_int ? bclk_int : ext_bclk_in;
   assign fs_out   = is_pass ? ext_fs_in : (fs_act ^ fs_inv);

   AST_FS_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fs_run && is_int) && (fs_act != $past(fs_act))) |-> $fell(bclk_int)); // R6
   AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(is_pass) |-> !fs_act); // R11
endmodule

// File: tb/frame_sync_gen_tb.sv
module frame_sync_gen_tb;
   localparam int DIV_W = 8;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]       mode;
   logic             clk_en, fs_en, periodic, fs_inv, xfer_req, ext_bclk, ext_fs;
   logic [DIV_W-1:0] div;
   logic [CNT_W-1:0] period_m1, width_m1;
   logic             bclk_out, fs_out;

   frame_sync_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .clk_en(clk_en), .fs_en(fs_en),
      .periodic(periodic), .fs_inv(fs_inv), .div(div), .period_m1(period_m1),
      .width_m1(width_m1), .xfer_req(xfer_req), .ext_bclk_in(ext_bclk),
      .ext_fs_in(ext_fs), .bclk_out(bclk_out), .fs_out(fs_out)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   // monitor state
   bit use_ext = 0, align_on = 0, prev_b = 0, prev_act = 0, prev_bo = 0;
   int fallcnt = 0, rise_cnt = 0, last_rise_at = 0, period_meas = 0, width_meas = 0;
   int align_bad = 0, last_fall_cyc = 0, rise_cyc = 0, bper = 0, bhigh = 0;

   always @(negedge clk) begin
      bit b, act, fell;
      b = use_ext ? ext_bclk : bclk_out;
      fell = prev_b && !b;
      if (fell) fallcnt++;
      prev_b = b;
      if (bclk_out && !prev_bo) rise_cyc = cyc;
      if (!bclk_out && prev_bo) begin
         bhigh = cyc - rise_cyc;
         bper = cyc - last_fall_cyc;
         last_fall_cyc = cyc;
      end
      prev_bo = bclk_out;
      act = fs_out ^ fs_inv;
      if (align_on && !use_ext && (act != prev_act) && !fell) align_bad++;
      if (act && !prev_act) begin
         rise_cnt++;
         period_meas = fallcnt - last_rise_at;
         last_rise_at = fallcnt;
      end
      if (!act && prev_act) width_meas = fallcnt - last_rise_at;
      prev_act = act;
   end

   initial begin
      ext_bclk = 1'b0;
      forever begin
         repeat (5) @(posedge clk);
         #1 ext_bclk = ~ext_bclk;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_bper(input int d);
      return ((d == 0) ? 1 : d) + 1;
   endfunction

   function automatic int exp_bhigh(input int d);
      int l;
      l = (d == 0) ? 1 : d;
      return (l + 1) - ((l + 1) / 2);
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_rises(input int n, input int limit);
      int target;
      target = rise_cnt + n;
      for (int i = 0; i < limit && rise_cnt < target; i++) @(posedge clk);
      #1;
   endtask

   task automatic stop_all();
      align_on = 0;
      clk_en = 0;
      fs_en = 0;
      step(3);
   endtask

   task automatic run_periodic(input int m, input int d, input int p, input int w, input bit inv);
      stop_all();
      mode = 2'(m); div = DIV_W'(d); period_m1 = CNT_W'(p); width_m1 = CNT_W'(w);
      fs_inv = inv; periodic = 1; use_ext = (m == 1);
      step(3);
      chk(fs_out == inv, "R5 idle level", fs_out, inv);
      clk_en = 1;
      step(2);
      fs_en = 1;
      wait_rises(1, 20000);
      if (!use_ext) align_on = 1;
      wait_rises(3, 30000);
      chk(period_meas == p + 1, (m == 1) ? "R10 R3 period" : "R3 period", period_meas, p + 1);
      chk(width_meas == w + 1, (m == 1) ? "R10 R4 width" : "R4 width", width_meas, w + 1);
      stop_all();
   endtask

   initial begin
      int r0, f0, lows, seed_v;
      seed_v = $urandom(32'h5eed_1234);
      mode = 0; clk_en = 0; fs_en = 0; periodic = 1; fs_inv = 1; xfer_req = 0; ext_fs = 0;
      div = 2; period_m1 = 7; width_m1 = 3;
      step(5);
      chk(bclk_out == 1'b0, "R1 bclk in reset", bclk_out, 0);
      chk(fs_out == 1'b1, "R1 fs in reset", fs_out, 1);
      rst_n = 1;
      step(2);

      // R2 divider shape
      for (int d = 0; d < 5; d++) begin
         stop_all();
         mode = 0; div = DIV_W'(d); use_ext = 0;
         clk_en = 1;
         step(40);
         chk(bper == exp_bper(d), "R2 bclk period", bper, exp_bper(d));
         chk(bhigh == exp_bhigh(d), "R2 bclk high", bhigh, exp_bhigh(d));
      end

      // R7 first pulse right after enable
      stop_all();
      mode = 0; div = 2; period_m1 = 7; width_m1 = 3; fs_inv = 0; periodic = 1; use_ext = 0;
      clk_en = 1;
      step(20);
      fs_en = 1;
      @(posedge clk);
      f0 = fallcnt;
      wait_rises(1, 2000);
      chk(last_rise_at == f0 + 1, "R7 first pulse", last_rise_at - f0, 1);

      // R9 frame enable without clock enable
      stop_all();
      fs_en = 1;
      r0 = rise_cnt; f0 = fallcnt;
      step(60);
      chk(rise_cnt == r0, "R9 no strobe without clk_en", rise_cnt - r0, 0);
      chk(bclk_out == 1'b0, "R9 bclk quiet", bclk_out, 0);
      clk_en = 1;
      wait_rises(2, 2000);
      clk_en = 0;
      step(2);
      chk(fs_out == fs_inv, "R9 stop fs", fs_out, fs_inv);
      chk(bclk_out == 1'b0, "R9 stop bclk", bclk_out, 0);

      // R4 width at or beyond the period
      for (int k = 0; k < 2; k++) begin
         stop_all();
         mode = 0; div = 1; period_m1 = 5; width_m1 = (k == 0) ? 9 : 5; fs_inv = k[0];
         clk_en = 1; step(2); fs_en = 1;
         wait_rises(1, 2000);
         r0 = rise_cnt; lows = 0;
         for (int i = 0; i < 100; i++) begin
            step(1);
            if ((fs_out ^ fs_inv) != 1'b1) lows++;
         end
         chk(lows == 0 && rise_cnt == r0, "R4 continuous strobe", lows, 0);
      end

      // R8 one-shot
      stop_all();
      mode = 0; div = 1; period_m1 = 6; width_m1 = 2; fs_inv = 1; periodic = 0;
      clk_en = 1; step(2); fs_en = 1;
      r0 = rise_cnt;
      step(100);
      chk(rise_cnt == r0, "R8 no frame without request", rise_cnt - r0, 0);
      xfer_req = 1; step(1); xfer_req = 0;
      step(200);
      chk(rise_cnt == r0 + 1, "R8 one frame per request", rise_cnt - r0, 1);
      chk(width_meas == 3, "R8 one-shot width", width_meas, 3);
      r0 = rise_cnt;
      xfer_req = 1; step(1); xfer_req = 0;
      step(6);
      xfer_req = 1; step(1); xfer_req = 0;
      step(200);
      chk(rise_cnt == r0 + 2, "R8 queued request", rise_cnt - r0, 2);

      // R10 external clock
      run_periodic(1, 0, 5, 1, 0);
      stop_all();
      mode = 1; clk_en = 1;
      step(3);
      @(negedge clk);
      chk(bclk_out == ext_bclk, "R10 bclk follows pin", bclk_out, ext_bclk);
      step(1);

      // R11 pass-through
      for (int m = 2; m < 4; m++) begin
         stop_all();
         mode = 2'(m); fs_inv = 1; clk_en = 1; fs_en = 1; periodic = 1; ext_fs = 1;
         step(3);
         @(negedge clk);
         chk(fs_out == 1'b1, "R11 fs pass high", fs_out, 1);
         chk(bclk_out == ext_bclk, "R11 bclk pass", bclk_out, ext_bclk);
         step(1);
         ext_fs = 0;
         @(negedge clk);
         chk(fs_out == 1'b0, "R11 fs pass low", fs_out, 0);
         step(1);
      end

      // random configurations
      for (int i = 0; i < 14; i++) begin
         int d, p, w, m;
         bit inv;
         d = $urandom_range(0, 4);
         p = $urandom_range(1, 15);
         w = $urandom_range(0, p - 1);
         inv = 1'($urandom_range(0, 1));
         m = (i % 4 == 3) ? 1 : 0;
         run_periodic(m, d, p, w, inv);
      end

      chk(align_bad == 0, "R6 strobe on bclk fall", align_bad, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule